// File: doc/BRIEF.md
# Pseudo-SRAM Power Mode Sequencer

This block is a synchronous power-state manager that sits between a bus controller and a pseudo-SRAM. It owns the memory's deep-power-down pin and the chip-enable pin while the memory is not yet usable. After power comes up, and again after every exit from deep power down, it enforces a settling wait. It then completes one of two wake-up methods before it reports the memory ready and passes chip-enable control to the bus controller.

Wait lengths are given in nanoseconds and converted to clock cycles from a clock-period parameter, with rounding up. A parameter picks the wake-up method. In the dummy-read method, the block asks the bus controller for a fixed number of reads and counts their acknowledgements. In the extended-hold method, it keeps chip enable high for a further interval. While the memory is ready, the block sorts the bus activity into an active state and a standby state. It accepts requests to enter and leave deep power down, and it keeps a sticky flag recording that stored data has been lost.

Top module: `psram_pwr_seq`

## Requirements
- R1: While `rst` is high, and after it while `pwr_good` stays low, the block outputs `power_state` = 0 (off), `mem_ce2` = 1, `mem_ce1_n` = 1, `ready` = 0, `dummy_rd_req` = 0 and `data_lost` = 0.
- R2: The first clock edge that sees `pwr_good` high enters the settling state (`power_state` = 1). The block stays there for exactly INIT_CYC = ceil(INIT_WAIT_NS*1000/CLK_PERIOD_PS) cycles, with `ready` low and no read request.
- R3: With WAKE_HOLD = 0, the settling state is followed by the dummy-read state (`power_state` = 3). In that state `dummy_rd_req` is held high until the DUMMY_READS-th cycle in which `dummy_rd_ack` is high. `dummy_rd_req` drops at that edge, and the block leaves the state one edge later.
- R4: With WAKE_HOLD = 1, the settling state is followed by the hold state (`power_state` = 2). The block stays there for HOLD_CYC = ceil(HOLD_WAIT_NS*1000/CLK_PERIOD_PS) cycles. Throughout, `mem_ce1_n` stays high whatever `bus_ce_n` does, and no read is requested.
- R5: `ready` is high exactly when `power_state` is 4 (active) or 5 (standby).
- R6: While ready, the state is standby when `bus_ce_n` is high or both bits of `bus_be_n` are high, and active otherwise. `mem_ce1_n` follows `bus_ce_n` one cycle later in the active, standby and dummy-read states, and is high in all other states.
- R7: A `dpd_req` pulse while ready enters deep power down (`power_state` = 6) at the next edge: `mem_ce2` low, `mem_ce1_n` high, `ready` low.
- R8: `mem_ce2` stays low for at least DPD_CYC = ceil(DPD_MIN_NS*1000/CLK_PERIOD_PS) cycles. A `wake_req` that arrives earlier is remembered, and the block exits into the settling state once DPD_CYC has elapsed.
- R9: The block leaves deep power down only on a `wake_req`. If the minimum time has already elapsed, it exits at the edge that sees the request.
- R10: `data_lost` goes high at the edge that enters deep power down and stays high until a `clear_lost` pulse clears it. Entry wins over a clear in the same cycle.
- R11: A `dpd_req` that arrives during the settling, hold or dummy-read states is held pending. When the wake-up sequence completes, the block goes straight to deep power down and does not raise `ready`.
- R12: From any state, `pwr_good` low returns the block to the off state at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Memory supply is up |
| dpd_req | input | 1 | Request to enter deep power down (pulse) |
| wake_req | input | 1 | Request to leave deep power down (pulse) |
| clear_lost | input | 1 | Clears the data-lost flag |
| bus_ce_n | input | 1 | Chip enable from the bus controller, active low |
| bus_be_n | input | 2 | Byte enables from the bus controller, active low |
| dummy_rd_ack | input | 1 | One-cycle completion strobe for a dummy read |
| mem_ce2 | output | 1 | Deep-power-down pin of the memory, low = power down |
| mem_ce1_n | output | 1 | Chip enable pin of the memory, active low |
| ready | output | 1 | Memory may be used by the bus controller |
| dummy_rd_req | output | 1 | Request for the bus controller to perform a dummy read |
| data_lost | output | 1 | Sticky flag: deep power down was entered |
| power_state | output | 3 | Current state code (0 off, 1 settling, 2 hold, 3 dummy read, 4 active, 5 standby, 6 deep power down) |

## Verification
The bench builds two instances with a 10 ns clock period and waits of 200 ns, 300 ns and 50 ns. This gives INIT_CYC = 20, HOLD_CYC = 30 and DPD_CYC = 5, which brings every interval boundary within a few dozen cycles. One instance uses the dummy-read method with two reads and covers spaced and back-to-back acknowledgements. The other uses the extended-hold method and drives `bus_ce_n` low during the hold to show that it is blocked. A deep-power-down request made while waking, and a wake request made before the minimum low time, are both exercised on the dummy-read instance.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [2:0] {
    PS_OFF     = 3'd0,
    PS_INIT    = 3'd1,
    PS_HOLD    = 3'd2,
    PS_DUMMY   = 3'd3,
    PS_ACTIVE  = 3'd4,
    PS_STANDBY = 3'd5,
    PS_DPD     = 3'd6
  } pwr_state_e;

  // Round a duration in ns up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int ns, input int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pps_wait_timer.sv
module pps_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pps_dummy_reader.sv
module pps_dummy_reader #(
  parameter int NREADS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic keep,
  input  logic ack,
  output logic req,
  output logic done
);

  localparam int CW = (NREADS < 2) ? 1 : $clog2(NREADS + 1);
  localparam logic [CW-1:0] LAST = CW'(NREADS - 1);

  logic [CW-1:0] cnt_q;
  logic          req_q;
  logic          done_q;
  logic          last_ack;

  assign last_ack = req_q && ack && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (arm) begin
      cnt_q  <= '0;
      req_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (!keep) begin
      req_q <= 1'b0;
    end else if (req_q && ack) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_ack) begin
        req_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign req  = req_q;
  assign done = done_q;

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int INIT_WAIT_NS  = 200000,
  parameter int HOLD_WAIT_NS  = 300000,
  parameter int DPD_MIN_NS    = 1000,
  parameter int WAKE_HOLD     = 0,
  parameter int DUMMY_READS   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good,
  input  logic       dpd_req,
  input  logic       wake_req,
  input  logic       clear_lost,
  input  logic       bus_ce_n,
  input  logic [1:0] bus_be_n,
  input  logic       dummy_rd_ack,
  output logic       mem_ce2,
  output logic       mem_ce1_n,
  output logic       ready,
  output logic       dummy_rd_req,
  output logic       data_lost,
  output logic [2:0] power_state
);

  localparam int INIT_CYC = ns_to_cycles(INIT_WAIT_NS, CLK_PERIOD_PS);
  localparam int HOLD_CYC = ns_to_cycles(HOLD_WAIT_NS, CLK_PERIOD_PS);
  localparam int DPD_CYC  = ns_to_cycles(DPD_MIN_NS, CLK_PERIOD_PS);
  localparam int MAX_CYC  = max3(INIT_CYC, HOLD_CYC, DPD_CYC);
  localparam int TW       = $clog2(MAX_CYC + 1);
  localparam pwr_state_e AFTER_INIT = (WAKE_HOLD != 0) ? PS_HOLD : PS_DUMMY;

  pwr_state_e    state_q, state_d, run_state, finish_state;
  logic          dpd_pend_q, wake_pend_q;
  logic          ce2_q, ce1_n_q, ready_q, lost_q;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          rd_req, rd_done, rd_arm, rd_keep;
  logic          bus_quiet, waking;

  assign bus_quiet    = bus_ce_n || (&bus_be_n);
  assign run_state    = bus_quiet ? PS_STANDBY : PS_ACTIVE;
  assign finish_state = (dpd_pend_q || dpd_req) ? PS_DPD : run_state;
  assign waking       = (state_q == PS_INIT) || (state_q == PS_HOLD) ||
                        (state_q == PS_DUMMY);

  // Next-state selection
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_OFF:     state_d = PS_INIT;
      PS_INIT:    if (tmr_expired) state_d = AFTER_INIT;
      PS_HOLD:    if (tmr_expired) state_d = finish_state;
      PS_DUMMY:   if (rd_done) state_d = finish_state;
      PS_ACTIVE,
      PS_STANDBY: state_d = dpd_req ? PS_DPD : run_state;
      PS_DPD:     if (tmr_expired && (wake_pend_q || wake_req)) state_d = PS_INIT;
      default:    state_d = PS_OFF;
    endcase
    if (!pwr_good) state_d = PS_OFF;
  end

  // Interval timer, reloaded on every state change
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      PS_INIT: tmr_val = TW'(INIT_CYC - 1);
      PS_HOLD: tmr_val = TW'(HOLD_CYC - 1);
      PS_DPD:  tmr_val = TW'(DPD_CYC - 1);
      default: tmr_val = '0;
    endcase
  end

  pps_wait_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  assign rd_arm  = (state_d == PS_DUMMY) && (state_q != PS_DUMMY);
  assign rd_keep = (state_d == PS_DUMMY);

  generate
    if (WAKE_HOLD == 0) begin : g_dummy
      pps_dummy_reader #(.NREADS(DUMMY_READS)) u_reader (
        .clk  (clk),
        .rst  (rst),
        .arm  (rd_arm),
        .keep (rd_keep),
        .ack  (dummy_rd_ack),
        .req  (rd_req),
        .done (rd_done)
      );
    end else begin : g_hold
      assign rd_req  = 1'b0;
      assign rd_done = 1'b0;
    end
  endgenerate

  // State, pending requests and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PS_OFF;
      dpd_pend_q  <= 1'b0;
      wake_pend_q <= 1'b0;
      ce2_q       <= 1'b1;
      ce1_n_q     <= 1'b1;
      ready_q     <= 1'b0;
      lost_q      <= 1'b0;
    end else begin
      state_q <= state_d;

      if ((state_d == PS_DPD) || (state_d == PS_OFF)) begin
        dpd_pend_q <= 1'b0;
      end else if (dpd_req && waking) begin
        dpd_pend_q <= 1'b1;
      end

      if (state_d != PS_DPD) begin
        wake_pend_q <= 1'b0;
      end else if ((state_q == PS_DPD) && wake_req) begin
        wake_pend_q <= 1'b1;
      end

      ce2_q   <= (state_d != PS_DPD);
      ready_q <= (state_d == PS_ACTIVE) || (state_d == PS_STANDBY);
      if ((state_d == PS_ACTIVE) || (state_d == PS_STANDBY) || (state_d == PS_DUMMY)) begin
        ce1_n_q <= bus_ce_n;
      end else begin
        ce1_n_q <= 1'b1;
      end

      if ((state_d == PS_DPD) && (state_q != PS_DPD)) begin
        lost_q <= 1'b1;
      end else if (clear_lost) begin
        lost_q <= 1'b0;
      end
    end
  end

  assign mem_ce2      = ce2_q;
  assign mem_ce1_n    = ce1_n_q;
  assign ready        = ready_q;
  assign dummy_rd_req = rd_req;
  assign data_lost    = lost_q;
  assign power_state  = state_q;

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        pwr_good,
  input logic        mem_ce2,
  input logic        mem_ce1_n,
  input logic        ready,
  input logic        dummy_rd_req,
  input logic        data_lost,
  input logic [2:0]  power_state,
  input int          dpd_min_cyc
);

  int low_cnt;

  always_ff @(posedge clk) begin
    if (rst || mem_ce2) low_cnt <= 0;
    else if (low_cnt < 32'h3fff_ffff) low_cnt <= low_cnt + 1;
  end

  assert_ready_state_R5: assert property (@(posedge clk) disable iff (rst)
    ready == ((power_state == 3'd4) || (power_state == 3'd5)));

  assert_ce2_low_only_dpd_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_ce2 |-> (power_state == 3'd6) && mem_ce1_n && !ready);

  assert_dpd_min_low_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce2) |-> (low_cnt >= dpd_min_cyc));

  assert_hold_blocks_ce_R4: assert property (@(posedge clk) disable iff (rst)
    (power_state == 3'd2) |-> mem_ce1_n);

  assert_req_in_dummy_R3: assert property (@(posedge clk) disable iff (rst)
    dummy_rd_req |-> (power_state == 3'd3));

  assert_lost_on_entry_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(data_lost) |-> (power_state == 3'd6));

  assert_power_loss_R12: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (power_state == 3'd0));

endmodule

bind psram_pwr_seq psram_pwr_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .pwr_good     (pwr_good),
  .mem_ce2      (mem_ce2),
  .mem_ce1_n    (mem_ce1_n),
  .ready        (ready),
  .dummy_rd_req (dummy_rd_req),
  .data_lost    (data_lost),
  .power_state  (power_state),
  .dpd_min_cyc  (DPD_CYC)
);

// File: tb/psram_pwr_seq_tb.sv
module psram_pwr_seq_tb;

  localparam int S_STATE = 0, S_READY = 1, S_CE2 = 2, S_CE1N = 3, S_LOST = 4, S_RDREQ = 5;

  typedef struct {
    int    sig;
    int    val;
    bit    hold_dut;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 1'b0, dpd_req = 1'b0, wake_req = 1'b0, clear_lost = 1'b0;
  logic bus_ce_n = 1'b1;
  logic [1:0] bus_be_n = 2'b00;
  logic rd_ack = 1'b0;
  logic h_pwr_good = 1'b0;

  logic mem_ce2, mem_ce1_n, ready, dummy_rd_req, data_lost;
  logic [2:0] power_state;
  logic h_ce2, h_ce1_n, h_ready, h_rd_req, h_lost;
  logic [2:0] h_state;

  exp_t exp_q[$];
  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  psram_pwr_seq #(.CLK_PERIOD_PS(10000), .INIT_WAIT_NS(200), .HOLD_WAIT_NS(300),
                  .DPD_MIN_NS(50), .WAKE_HOLD(0), .DUMMY_READS(2)) u_dut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .dpd_req(dpd_req), .wake_req(wake_req),
    .clear_lost(clear_lost), .bus_ce_n(bus_ce_n), .bus_be_n(bus_be_n),
    .dummy_rd_ack(rd_ack), .mem_ce2(mem_ce2), .mem_ce1_n(mem_ce1_n), .ready(ready),
    .dummy_rd_req(dummy_rd_req), .data_lost(data_lost), .power_state(power_state));

  psram_pwr_seq #(.CLK_PERIOD_PS(10000), .INIT_WAIT_NS(200), .HOLD_WAIT_NS(300),
                  .DPD_MIN_NS(50), .WAKE_HOLD(1), .DUMMY_READS(2)) u_dut_hold (
    .clk(clk), .rst(rst), .pwr_good(h_pwr_good), .dpd_req(1'b0), .wake_req(1'b0),
    .clear_lost(1'b0), .bus_ce_n(bus_ce_n), .bus_be_n(bus_be_n),
    .dummy_rd_ack(1'b0), .mem_ce2(h_ce2), .mem_ce1_n(h_ce1_n), .ready(h_ready),
    .dummy_rd_req(h_rd_req), .data_lost(h_lost), .power_state(h_state));

  function automatic int observe(input int sig, input bit hd);
    case (sig)
      S_STATE: return hd ? int'(h_state) : int'(power_state);
      S_READY: return hd ? int'(h_ready) : int'(ready);
      S_CE2:   return hd ? int'(h_ce2)   : int'(mem_ce2);
      S_CE1N:  return hd ? int'(h_ce1_n) : int'(mem_ce1_n);
      S_LOST:  return hd ? int'(h_lost)  : int'(data_lost);
      default: return hd ? int'(h_rd_req) : int'(dummy_rd_req);
    endcase
  endfunction

  // Monitor: compares every queued expectation at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        int act;
        e = exp_q.pop_front();
        act = observe(e.sig, e.hold_dut);
        tests++;
        if (act != e.val) begin
          fails++;
          $display("FAIL %s: signal %0d actual %0d expected %0d", e.req, e.sig, act, e.val);
        end
      end
    end
  end

  task automatic expect_val(input int sig, input int val, input string req, input bit hd = 1'b0);
    exp_t e;
    e.sig = sig; e.val = val; e.req = req; e.hold_dut = hd;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    step(3);
    // R1: reset state
    expect_val(S_STATE, 0, "R1"); expect_val(S_CE2, 1, "R1"); expect_val(S_CE1N, 1, "R1");
    expect_val(S_READY, 0, "R1"); expect_val(S_LOST, 0, "R1"); expect_val(S_RDREQ, 0, "R1");
    rst = 1'b0;
    step(1);
    expect_val(S_STATE, 0, "R1");
    // R2: power-up settling interval
    pwr_good = 1'b1;
    step(1);
    expect_val(S_STATE, 1, "R2"); expect_val(S_READY, 0, "R2");
    step(19);
    expect_val(S_STATE, 1, "R2"); expect_val(S_RDREQ, 0, "R2");
    step(1);
    // R3: dummy reads
    expect_val(S_STATE, 3, "R3"); expect_val(S_RDREQ, 1, "R3"); expect_val(S_READY, 0, "R3");
    rd_ack = 1'b1; step(1); rd_ack = 1'b0;
    expect_val(S_RDREQ, 1, "R3"); expect_val(S_STATE, 3, "R3");
    step(3);
    expect_val(S_READY, 0, "R3");
    rd_ack = 1'b1; step(1); rd_ack = 1'b0;
    expect_val(S_RDREQ, 0, "R3"); expect_val(S_READY, 0, "R3");
    step(1);
    expect_val(S_STATE, 5, "R5"); expect_val(S_READY, 1, "R5"); expect_val(S_CE1N, 1, "R6");
    // R6: activity classification and chip-enable pass-through
    bus_ce_n = 1'b0; bus_be_n = 2'b10;
    step(1);
    expect_val(S_STATE, 4, "R6"); expect_val(S_CE1N, 0, "R6"); expect_val(S_READY, 1, "R5");
    bus_be_n = 2'b11;
    step(1);
    expect_val(S_STATE, 5, "R6"); expect_val(S_CE1N, 0, "R6");
    bus_ce_n = 1'b1; bus_be_n = 2'b00;
    step(1);
    expect_val(S_STATE, 5, "R6"); expect_val(S_CE1N, 1, "R6");
    // R7 / R10: deep power down entry
    bus_ce_n = 1'b0; dpd_req = 1'b1;
    step(1); dpd_req = 1'b0;
    expect_val(S_STATE, 6, "R7"); expect_val(S_CE2, 0, "R7"); expect_val(S_CE1N, 1, "R7");
    expect_val(S_READY, 0, "R7"); expect_val(S_LOST, 1, "R10");
    // R8: early wake is remembered, minimum low time honoured
    wake_req = 1'b1; step(1); wake_req = 1'b0;
    expect_val(S_CE2, 0, "R8");
    step(3);
    expect_val(S_STATE, 6, "R8"); expect_val(S_CE2, 0, "R8");
    step(1);
    expect_val(S_STATE, 1, "R8"); expect_val(S_CE2, 1, "R8"); expect_val(S_LOST, 1, "R10");
    // R10: clear
    clear_lost = 1'b1; step(1); clear_lost = 1'b0;
    expect_val(S_LOST, 0, "R10"); expect_val(S_STATE, 1, "R10");
    // R11: power-down request during wake-up is held
    dpd_req = 1'b1; step(1); dpd_req = 1'b0;
    expect_val(S_STATE, 1, "R11"); expect_val(S_CE2, 1, "R11"); expect_val(S_READY, 0, "R11");
    step(18);
    expect_val(S_STATE, 3, "R11"); expect_val(S_RDREQ, 1, "R3");
    rd_ack = 1'b1; step(2); rd_ack = 1'b0;
    expect_val(S_STATE, 3, "R3"); expect_val(S_RDREQ, 0, "R3"); expect_val(S_READY, 0, "R11");
    step(1);
    expect_val(S_STATE, 6, "R11"); expect_val(S_READY, 0, "R11"); expect_val(S_CE2, 0, "R11");
    expect_val(S_CE1N, 1, "R11"); expect_val(S_LOST, 1, "R10");
    // R9: no exit without a wake request
    step(10);
    expect_val(S_STATE, 6, "R9"); expect_val(S_CE2, 0, "R9");
    wake_req = 1'b1; step(1); wake_req = 1'b0;
    expect_val(S_STATE, 1, "R9"); expect_val(S_CE2, 1, "R9");
    // R12: power loss
    pwr_good = 1'b0;
    step(1);
    expect_val(S_STATE, 0, "R12"); expect_val(S_READY, 0, "R12"); expect_val(S_CE2, 1, "R12");
    // R4: extended-hold instance, bus tries to select during the hold
    bus_ce_n = 1'b0; bus_be_n = 2'b00;
    h_pwr_good = 1'b1;
    step(1);
    expect_val(S_STATE, 1, "R2", 1'b1);
    step(19);
    expect_val(S_STATE, 1, "R2", 1'b1);
    step(1);
    expect_val(S_STATE, 2, "R4", 1'b1); expect_val(S_CE1N, 1, "R4", 1'b1);
    expect_val(S_RDREQ, 0, "R4", 1'b1);
    step(29);
    expect_val(S_STATE, 2, "R4", 1'b1); expect_val(S_CE1N, 1, "R4", 1'b1);
    expect_val(S_READY, 0, "R4", 1'b1);
    step(1);
    expect_val(S_STATE, 4, "R4", 1'b1); expect_val(S_READY, 1, "R5", 1'b1);
    expect_val(S_CE1N, 0, "R6", 1'b1);
    @(negedge clk);
    #1;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run incomplete, actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule